// File: doc/BRIEF.md
# Bonded-Pair Weighted Round-Robin Port Arbiter

This block picks one of several request ports per clock for a shared memory controller core. Each port has a priority level, where 0 is the most urgent, and a win budget. A single scan order lists every port index. Among the ports at the most urgent requesting level, the one placed earliest in that list wins. When a port has used up its budget, it moves to the tail of the list and its win count restarts from zero. Since each priority level only looks at the ports it contains, moving a port to the tail moves it to the bottom of its own group.

Neighbouring ports 2k and 2k+1 can be bonded by setting bit k of a pair-enable vector. When the port count is odd, the last port is never bonded. A bonded pair acts as one unit:
- it keeps a single win counter;
- it arbitrates at the level of its even member;
- it moves to the tail of the list as an adjacent couple, even port first.

Inside the unit, a port that requests alone wins. If both request, the even port wins.

A per-port relax input lets a starved port jump ahead of normal arbitration. A sticky error flag reports an illegal bonding.

The request, relax and grant pins are plain level signals. There is no data stream, so there is no valid/ready handshake and no back-pressure. The configuration pins are also plain; they are captured only on a clock edge where no port is requesting.

Top module: `pwrr_arbiter`

## Requirements
- R1: After reset, `grant` is 0, `cfg_err` is 0, and the scan order holds port i at position i. Position i occupies bits [3i+2:3i] of `scan_order`.
- R2: On each rising edge, `grant` is loaded with at most one set bit, and only for a port whose `req` was high before that edge. If no port was requesting, `grant` is loaded with 0.
- R3: Without relaxed requesters, the winner comes from the lowest-numbered requesting level. Within that level, the winner is the port found first in the scan order.
- R4: Each grant increments the winning unit's counter. When the count reaches the unit's weight (a weight of 0 counts as 1), the counter clears and the unit moves to the tail of the scan order. All other entries keep their relative order.
- R5: When bit k of `cfg_pair` is set, ports 2k and 2k+1 form one unit. The unit uses port 2k's weight and level, increments one shared counter on a grant to either member, and rotates to the tail as the pair 2k followed by 2k+1.
- R6: Within a bonded unit, a port that requests alone wins. When both ports request, port 2k wins.
- R7: A port with both `req` and `relax` high beats every non-relaxed requester, whatever the levels. Among several such ports, the lowest index wins. The grant counts toward the counter of that port's unit.
- R8: `cfg_level`, `cfg_weight` and `cfg_pair` are captured only on an edge where `req` is all zero. Changes made while any request is high have no effect.
- R9: On a capture edge, `cfg_err` is set if any enabled pair has unequal weights, or if its even port is not immediately ahead of its odd port in the scan order. Once set, `cfg_err` stays high until reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req | input | NPORTS | Request level per port |
| relax | input | NPORTS | Starvation promote per port |
| cfg_level | input | NPORTS*LVL_W | Priority level per port, where 0 is most urgent |
| cfg_weight | input | NPORTS*WGT_W | Wins per turn for each port |
| cfg_pair | input | NPORTS/2 | Bond enable per adjacent pair |
| grant | output | NPORTS | One-hot registered grant |
| scan_order | output | NPORTS*IDX_W | Port index at each scan position |
| cfg_err | output | 1 | Sticky illegal-bonding flag |

## Verification
The request seen before edge n shows up in `grant` and in the rotated `scan_order` right after edge n. The bench therefore drives on a falling edge and reads both outputs on the next falling edge. Configuration is held for a request-free cycle, so it is captured at that edge. `cfg_err` responds on that same edge, and the new weights first govern the request presented on the following cycle. The hold-off test changes the weights while requests stay high and checks the grant three cycles later, which is the first point where a wrongly captured weight would change the winner.

// File: rtl/pwrr_pkg.sv
package pwrr_pkg;
  localparam int unsigned PORTS_DEF = 6;
  localparam int unsigned LVL_W_DEF = 2;
  localparam int unsigned WGT_W_DEF = 4;

  // Unit owner of a port: the even member when bonded, the port itself otherwise.
  function automatic int unsigned unit_lead(int unsigned idx, logic bonded);
    return bonded ? (idx & ~32'd1) : idx;
  endfunction
endpackage

// File: rtl/pwrr_cfg.sv
module pwrr_cfg #(
  parameter  int unsigned NPORTS = pwrr_pkg::PORTS_DEF,
  parameter  int unsigned LVL_W  = pwrr_pkg::LVL_W_DEF,
  parameter  int unsigned WGT_W  = pwrr_pkg::WGT_W_DEF,
  localparam int unsigned IDX_W  = $clog2(NPORTS),
  localparam int unsigned NPAIRS = NPORTS / 2
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              idle,
  input  logic [NPORTS-1:0][LVL_W-1:0]      lvl_in,
  input  logic [NPORTS-1:0][WGT_W-1:0]      wgt_in,
  input  logic [NPAIRS-1:0]                 pair_in,
  input  logic [NPORTS-1:0][IDX_W-1:0]      order,
  output logic [NPORTS-1:0][LVL_W-1:0]      lvl_q,
  output logic [NPORTS-1:0][WGT_W-1:0]      wgt_q,
  output logic [NPAIRS-1:0]                 pair_q,
  output logic                              err_q
);
  logic [NPAIRS-1:0] bad;

  // Legality of each requested bond against the live scan order.
  for (genvar k = 0; k < NPAIRS; k++) begin : g_chk
    logic adj;
    always_comb begin
      adj = 1'b0;
      for (int i = 0; i < NPORTS - 1; i++) begin
        if (order[i] == IDX_W'(2 * k) && order[i + 1] == IDX_W'(2 * k + 1))
          adj = 1'b1;
      end
    end
    assign bad[k] = pair_in[k] && (!adj || (wgt_in[2 * k] != wgt_in[2 * k + 1]));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lvl_q  <= '0;
      wgt_q  <= '0;
      pair_q <= '0;
      err_q  <= 1'b0;
    end else if (idle) begin
      lvl_q  <= lvl_in;
      wgt_q  <= wgt_in;
      pair_q <= pair_in;
      err_q  <= err_q | (|bad);
    end
  end
endmodule

// File: rtl/pwrr_pick.sv
module pwrr_pick #(
  parameter  int unsigned NPORTS = pwrr_pkg::PORTS_DEF,
  parameter  int unsigned LVL_W  = pwrr_pkg::LVL_W_DEF,
  localparam int unsigned IDX_W  = $clog2(NPORTS),
  localparam int unsigned NPAIRS = NPORTS / 2
) (
  input  logic [NPORTS-1:0]                 req,
  input  logic [NPORTS-1:0]                 relax,
  input  logic [NPORTS-1:0][LVL_W-1:0]      lvl_q,
  input  logic [NPAIRS-1:0]                 pair_q,
  input  logic [NPORTS-1:0][IDX_W-1:0]      order,
  output logic [IDX_W-1:0]                  win_idx,
  output logic                              win_any
);
  logic [NPORTS-1:0][LVL_W-1:0] eff;
  logic [NPORTS-1:0]            rel;
  logic [LVL_W-1:0]             best;

  // A bonded port borrows the level of the even member.
  for (genvar p = 0; p < NPORTS; p++) begin : g_eff
    if (p < 2 * NPAIRS) begin : g_pairable
      assign eff[p] = pair_q[p / 2] ? lvl_q[(p / 2) * 2] : lvl_q[p];
    end else begin : g_solo
      assign eff[p] = lvl_q[p];
    end
  end

  assign rel     = req & relax;
  assign win_any = |req;

  always_comb begin
    best = '1;
    for (int p = 0; p < NPORTS; p++) begin
      if (req[p] && eff[p] < best) best = eff[p];
    end
    win_idx = '0;
    if (|rel) begin
      for (int p = NPORTS - 1; p >= 0; p--) begin
        if (rel[p]) win_idx = IDX_W'(p);
      end
    end else begin
      for (int i = NPORTS - 1; i >= 0; i--) begin
        if (req[order[i]] && eff[order[i]] == best) win_idx = order[i];
      end
    end
  end
endmodule

// File: rtl/pwrr_rotate.sv
module pwrr_rotate #(
  parameter  int unsigned NPORTS = pwrr_pkg::PORTS_DEF,
  parameter  int unsigned WGT_W  = pwrr_pkg::WGT_W_DEF,
  localparam int unsigned IDX_W  = $clog2(NPORTS),
  localparam int unsigned NPAIRS = NPORTS / 2
) (
  input  logic [NPORTS-1:0][IDX_W-1:0]      order,
  input  logic [NPORTS-1:0][WGT_W-1:0]      cnt,
  input  logic [NPORTS-1:0][WGT_W-1:0]      wgt_q,
  input  logic [NPAIRS-1:0]                 pair_q,
  input  logic                              win_any,
  input  logic [IDX_W-1:0]                  win_idx,
  output logic [NPORTS-1:0][IDX_W-1:0]      order_nx,
  output logic [NPORTS-1:0][WGT_W-1:0]      cnt_nx
);
  logic             bonded;
  logic [IDX_W-1:0] leader;
  logic [IDX_W-1:0] mate;
  logic [WGT_W:0]   inc;
  logic [WGT_W:0]   lim;
  int               k;

  assign bonded = (32'(win_idx) < 2 * NPAIRS) && pair_q[win_idx >> 1];
  assign leader = IDX_W'(pwrr_pkg::unit_lead(32'(win_idx), bonded));
  assign mate   = bonded ? (leader | IDX_W'(1)) : leader;
  assign inc    = {1'b0, cnt[leader]} + (WGT_W + 1)'(1);
  assign lim    = (wgt_q[leader] == '0) ? (WGT_W + 1)'(1) : {1'b0, wgt_q[leader]};

  always_comb begin
    order_nx = order;
    cnt_nx   = cnt;
    k        = 0;
    if (win_any) begin
      if (inc >= lim) begin
        cnt_nx[leader] = '0;
        for (int i = 0; i < NPORTS; i++) begin
          if (order[i] != leader && order[i] != mate) begin
            order_nx[k] = order[i];
            k = k + 1;
          end
        end
        order_nx[k] = leader;
        if (bonded) order_nx[k + 1] = mate;
      end else begin
        cnt_nx[leader] = inc[WGT_W-1:0];
      end
    end
  end
endmodule

// File: rtl/pwrr_arbiter.sv
module pwrr_arbiter #(
  parameter  int unsigned NPORTS = pwrr_pkg::PORTS_DEF,
  parameter  int unsigned LVL_W  = pwrr_pkg::LVL_W_DEF,
  parameter  int unsigned WGT_W  = pwrr_pkg::WGT_W_DEF,
  localparam int unsigned IDX_W  = $clog2(NPORTS),
  localparam int unsigned NPAIRS = NPORTS / 2
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [NPORTS-1:0]          req,
  input  logic [NPORTS-1:0]          relax,
  input  logic [NPORTS*LVL_W-1:0]    cfg_level,
  input  logic [NPORTS*WGT_W-1:0]    cfg_weight,
  input  logic [NPAIRS-1:0]          cfg_pair,
  output logic [NPORTS-1:0]          grant,
  output logic [NPORTS*IDX_W-1:0]    scan_order,
  output logic                       cfg_err
);
  logic [NPORTS-1:0][LVL_W-1:0] lvl_in, lvl_q;
  logic [NPORTS-1:0][WGT_W-1:0] wgt_in, wgt_q;
  logic [NPAIRS-1:0]            pair_q;
  logic [NPORTS-1:0][IDX_W-1:0] ord_q, ord_nx;
  logic [NPORTS-1:0][WGT_W-1:0] cnt_q, cnt_nx;
  logic [NPORTS-1:0]            grant_q;
  logic [IDX_W-1:0]             win_idx;
  logic                         win_any;

  assign lvl_in = cfg_level;
  assign wgt_in = cfg_weight;

  pwrr_cfg #(.NPORTS(NPORTS), .LVL_W(LVL_W), .WGT_W(WGT_W)) u_cfg (
    .clk     (clk),
    .rst_n   (rst_n),
    .idle    (~|req),
    .lvl_in  (lvl_in),
    .wgt_in  (wgt_in),
    .pair_in (cfg_pair),
    .order   (ord_q),
    .lvl_q   (lvl_q),
    .wgt_q   (wgt_q),
    .pair_q  (pair_q),
    .err_q   (cfg_err)
  );

  pwrr_pick #(.NPORTS(NPORTS), .LVL_W(LVL_W)) u_pick (
    .req     (req),
    .relax   (relax),
    .lvl_q   (lvl_q),
    .pair_q  (pair_q),
    .order   (ord_q),
    .win_idx (win_idx),
    .win_any (win_any)
  );

  pwrr_rotate #(.NPORTS(NPORTS), .WGT_W(WGT_W)) u_rot (
    .order    (ord_q),
    .cnt      (cnt_q),
    .wgt_q    (wgt_q),
    .pair_q   (pair_q),
    .win_any  (win_any),
    .win_idx  (win_idx),
    .order_nx (ord_nx),
    .cnt_nx   (cnt_nx)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NPORTS; i++) ord_q[i] <= IDX_W'(i);
      cnt_q   <= '0;
      grant_q <= '0;
    end else begin
      ord_q   <= ord_nx;
      cnt_q   <= cnt_nx;
      grant_q <= win_any ? (NPORTS'(1) << win_idx) : '0;
    end
  end

  assign grant      = grant_q;
  assign scan_order = ord_q;
endmodule

// File: rtl/pwrr_arbiter_chk.sv
module pwrr_arbiter_chk #(
  parameter int unsigned NPORTS = 6,
  parameter int unsigned IDX_W  = 3
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic [NPORTS-1:0]       req,
  input logic [NPORTS-1:0]       grant,
  input logic [NPORTS*IDX_W-1:0] scan_order,
  input logic                    cfg_err
);
  logic [NPORTS-1:0] seen;

  always_comb begin
    seen = '0;
    for (int i = 0; i < NPORTS; i++) begin
      for (int p = 0; p < NPORTS; p++) begin
        if (scan_order[i*IDX_W +: IDX_W] == IDX_W'(p)) seen[p] = 1'b1;
      end
    end
  end

  // R2: never more than one grant
  a_r2_onehot: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(grant));

  // R2: a grant only goes to a port that requested before the edge
  a_r2_to_requester: assert property (@(posedge clk) disable iff (!rst_n)
    (|grant) |-> ((grant & $past(req)) != '0));

  // R2: no request, no grant
  a_r2_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (!(|req)) |=> (grant == '0));

  // R4: rotation keeps the scan order a permutation of the ports
  a_r4_order_perm: assert property (@(posedge clk) disable iff (!rst_n) (&seen));

  // R9: error flag never falls without reset
  a_r9_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_err |=> cfg_err);
endmodule

bind pwrr_arbiter pwrr_arbiter_chk #(.NPORTS(NPORTS), .IDX_W(IDX_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .req        (req),
  .grant      (grant),
  .scan_order (scan_order),
  .cfg_err    (cfg_err)
);

// File: tb/pwrr_arbiter_test.sv
module pwrr_arbiter_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [5:0]  req = '0;
  logic [5:0]  relax = '0;
  logic [11:0] cfg_level = '0;
  logic [23:0] cfg_weight = '0;
  logic [2:0]  cfg_pair = '0;
  logic [5:0]  grant;
  logic [17:0] scan_order;
  logic        cfg_err;

  int n_chk = 0;
  int n_fail = 0;

  always #5 clk = ~clk;

  pwrr_arbiter uut (
    .clk(clk), .rst_n(rst_n), .req(req), .relax(relax),
    .cfg_level(cfg_level), .cfg_weight(cfg_weight), .cfg_pair(cfg_pair),
    .grant(grant), .scan_order(scan_order), .cfg_err(cfg_err)
  );

  // req, relax, expected grant, expected order (nibble i = port at position i)
  typedef struct packed {
    logic [5:0]  rq;
    logic [5:0]  rx;
    logic [5:0]  gn;
    logic [23:0] od;
  } vec_t;

  // Config: all level 0, all weight 2, ports 0/1 bonded.
  localparam vec_t VECS [9] = '{
    '{6'h3F, 6'h00, 6'h01, 24'h543210},  // R5 pair counter 1
    '{6'h3F, 6'h00, 6'h01, 24'h105432},  // R5 pair rotates as a couple
    '{6'h3F, 6'h00, 6'h04, 24'h105432},  // R3 first in order
    '{6'h02, 6'h00, 6'h02, 24'h105432},  // R6 lone odd member
    '{6'h03, 6'h00, 6'h01, 24'h105432},  // R6 both -> even, R4 rotate
    '{6'h3F, 6'h00, 6'h04, 24'h210543},  // R4 port 2 reaches weight
    '{6'h3F, 6'h00, 6'h08, 24'h210543},  // R3
    '{6'h3F, 6'h20, 6'h20, 24'h210543},  // R7 relaxed wins
    '{6'h00, 6'h00, 6'h00, 24'h210543}   // R2 idle
  };

  function automatic logic [23:0] nib(input logic [17:0] so);
    logic [23:0] n = '0;
    for (int i = 0; i < 6; i++) n[i*4 +: 4] = {1'b0, so[i*3 +: 3]};
    return n;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic step(input logic [5:0] r, input logic [5:0] x);
    req = r;
    relax = x;
    @(negedge clk);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    req = '0;
    relax = '0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic configure(input logic [11:0] l, input logic [23:0] w, input logic [2:0] p);
    cfg_level = l;
    cfg_weight = w;
    cfg_pair = p;
    step(6'h00, 6'h00);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    // R1 reset state
    do_reset();
    @(negedge clk);
    chk("R1 grant", 32'(grant), 32'h0);
    chk("R1 order", 32'(nib(scan_order)), 32'h543210);
    chk("R1 err", 32'(cfg_err), 32'h0);

    // Vector table
    configure(12'h000, 24'h222222, 3'b001);
    chk("R9 legal pair no err", 32'(cfg_err), 32'h0);
    for (int v = 0; v < 9; v++) begin
      step(VECS[v].rq, VECS[v].rx);
      chk($sformatf("R2/R3/R4/R5 vec %0d grant", v), 32'(grant), 32'(VECS[v].gn));
      chk($sformatf("R4/R5 vec %0d order", v), 32'(nib(scan_order)), 32'(VECS[v].od));
    end

    // Levels and relax: ports 0-3 level 1, ports 4-5 level 0, weight 1
    do_reset();
    configure(12'h055, 24'h111111, 3'b000);
    step(6'h3F, 6'h00);
    chk("R3 urgent level wins", 32'(grant), 32'h10);
    chk("R4 order after win", 32'(nib(scan_order)), 32'h453210);
    step(6'h3F, 6'h00);
    chk("R3 second urgent", 32'(grant), 32'h20);
    step(6'h3F, 6'h0C);
    chk("R7 lowest relaxed", 32'(grant), 32'h04);
    chk("R7 relaxed rotates", 32'(nib(scan_order)), 32'h254310);
    step(6'h0F, 6'h00);
    chk("R3 lower level only", 32'(grant), 32'h01);

    // R8 config ignored while requests are pending
    do_reset();
    configure(12'h000, 24'h111111, 3'b000);
    cfg_weight = 24'h222222;
    step(6'h3F, 6'h00);
    chk("R8 step1", 32'(grant), 32'h01);
    step(6'h3F, 6'h00);
    chk("R8 step2", 32'(grant), 32'h02);
    step(6'h3F, 6'h00);
    chk("R8 held weight", 32'(grant), 32'h04);

    // R9 adjacency error
    do_reset();
    configure(12'h000, 24'h111111, 3'b000);
    chk("R9 no pair no err", 32'(cfg_err), 32'h0);
    step(6'h01, 6'h00);
    chk("R9 port0 moved", 32'(nib(scan_order)), 32'h054321);
    configure(12'h000, 24'h111111, 3'b001);
    chk("R9 split pair err", 32'(cfg_err), 32'h1);

    // R9 weight mismatch and stickiness
    do_reset();
    chk("R1 err cleared", 32'(cfg_err), 32'h0);
    configure(12'h000, 24'h111132, 3'b001);
    chk("R9 weight mismatch err", 32'(cfg_err), 32'h1);
    configure(12'h000, 24'h111111, 3'b001);
    chk("R9 sticky", 32'(cfg_err), 32'h1);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule